// File: doc/BRIEF.md
# Dual-Port RAM with Same-Word Busy Arbitration

This block is a synchronous memory with two fully independent ports, left and right. Each port has its own enable, write strobe, output enable, two byte-lane selects, word address and 16-bit data in and out. Both ports may access the array in the same cycle, including the same word. The default depth is kept small for elaboration. Setting `AW` to 14 gives the full 16K-word array.

When both ports touch the same word in one cycle and at least one of them writes, the block picks a winner and flags the other port as busy in that same cycle. The busy port's write is dropped. In master mode (`ms_sel` high) the block computes busy itself and drives it on the busy outputs. In slave mode (`ms_sel` low) the block ignores its own arbitration. Each port then takes its busy from the busy input, so an external master can make every device in a width-cascaded group lose together.

Read data is registered and appears one clock after the request. Byte lanes that were not selected read as zero.

Top module: `dpbusy_ram`

## Requirements
- R1: A write stores only the byte lanes whose selects are high. `*_ub` covers data bits 15:8 and `*_lb` covers bits 7:0. Unselected lanes of the word keep their old value.
- R2: A read with output enable high sets `*_dvalid` one clock later and drives the addressed word on `*_dout`, with unselected lanes at zero. Whenever `*_dvalid` is low, `*_dout` is zero. A write, or a read with output enable low, leaves `*_dvalid` low.
- R3: A port is in standby, and makes no access and takes part in no collision, when its enable is low or both of its byte selects are low.
- R4: A collision exists only when both ports are active on the same address and at least one of them writes. Two reads of the same word raise no busy.
- R5: In master mode, a port that was already active on the colliding address in the previous cycle wins against a port that newly arrives there. The newcomer is busy.
- R6: In master mode, when neither port or both ports held the colliding address from the previous cycle, the left port wins. At most one port is busy at any time.
- R7: A busy port's write does not change the array. A busy port's read returns the word as it was before the winner's write in that cycle.
- R8: Once a winner is chosen, it stays the winner for as long as the collision persists. Busy drops in the first cycle without a collision.
- R9: In master mode, the busy outputs carry the computed busy and the busy inputs are ignored. In slave mode, both busy outputs are low and each port's busy comes from its own busy input.
- R10: In slave mode, when neither port is busy and both write the same word in the same cycle, the left port's data takes precedence on byte lanes that both select.
- R11: While reset is asserted and until the first access after it, both busy outputs and both `*_dvalid` are low and both `*_dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_sel | input | 1 | 1 = master (busy computed and driven), 0 = slave (busy taken from inputs) |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port 1 = write, 0 = read |
| l_oe | input | 1 | Left port output enable |
| l_ub | input | 1 | Left port upper byte select (bits 15:8) |
| l_lb | input | 1 | Left port lower byte select (bits 7:0) |
| l_addr | input | AW | Left port word address |
| l_din | input | 16 | Left port write data |
| l_dout | output | 16 | Left port read data |
| l_dvalid | output | 1 | Left port read data is being driven |
| l_busy_in | input | 1 | Left port busy from an external master (slave mode) |
| l_busy_out | output | 1 | Left port busy computed here (master mode) |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port 1 = write, 0 = read |
| r_oe | input | 1 | Right port output enable |
| r_ub | input | 1 | Right port upper byte select (bits 15:8) |
| r_lb | input | 1 | Right port lower byte select (bits 7:0) |
| r_addr | input | AW | Right port word address |
| r_din | input | 16 | Right port write data |
| r_dout | output | 16 | Right port read data |
| r_dvalid | output | 1 | Right port read data is being driven |
| r_busy_in | input | 1 | Right port busy from an external master (slave mode) |
| r_busy_out | output | 1 | Right port busy computed here (master mode) |

## Verification
The hardest case to reach from the ports is the right port winning. It needs the right port to sit on a word for a cycle before the left port writes the same word. Otherwise the left-wins tie rule hides any fault in arrival tracking. The stimulus table therefore parks the right port on an address for one row and brings the left port in on the next. It also holds a collision across two rows to show the winner stays fixed, then ends it to show busy releases. In slave mode the busy inputs are driven directly. This shows a write blocked by an external master, and an unblocked same-word double write in which the left lanes take precedence.

// File: rtl/dpbusy_pkg.sv
package dpbusy_pkg;
  localparam int DATA_W    = 16;
  localparam int NUM_BYTES = DATA_W / 8;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // decoded per-port request
  typedef struct packed {
    logic                 act;
    logic                 wr;
    logic                 oe;
    logic [NUM_BYTES-1:0] be;
  } port_ctl_t;
endpackage

// File: rtl/dpbusy_port.sv
module dpbusy_port
  import dpbusy_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic              oe,
  input  logic              ub,
  input  logic              lb,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] raw_q,
  output port_ctl_t         ctl,
  output logic              hold,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid
);
  logic                 act_q, act_d;
  logic [AW-1:0]        addr_q, addr_d;
  logic                 dv_q, dv_d;
  logic [NUM_BYTES-1:0] mask_q, mask_d;
  logic                 rd_fire;
  logic [DATA_W-1:0]    lane_mask;

  always_comb begin
    ctl.be  = {ub, lb};
    ctl.act = en & (ub | lb);
    ctl.wr  = ctl.act & wr;
    ctl.oe  = oe;
  end

  assign rd_fire = ctl.act & ~wr & oe;
  assign hold    = ctl.act & act_q & (addr == addr_q);

  // next-state
  always_comb begin
    act_d  = ctl.act;
    addr_d = ctl.act ? addr : addr_q;
    dv_d   = rd_fire;
    mask_d = rd_fire ? ctl.be : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      dv_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      act_q  <= act_d;
      addr_q <= addr_d;
      dv_q   <= dv_d;
      mask_q <= mask_d;
    end
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{mask_q[b]}};
  end

  assign dvalid = dv_q;
  assign dout   = dv_q ? (raw_q & lane_mask) : '0;
endmodule

// File: rtl/dpbusy_bank.sv
module dpbusy_bank
  import dpbusy_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 we_l,
  input  logic                 re_l,
  input  logic [NUM_BYTES-1:0] be_l,
  input  logic [AW-1:0]        addr_l,
  input  logic [DATA_W-1:0]    wd_l,
  output logic [DATA_W-1:0]    q_l,
  input  logic                 we_r,
  input  logic                 re_r,
  input  logic [NUM_BYTES-1:0] be_r,
  input  logic [AW-1:0]        addr_r,
  input  logic [DATA_W-1:0]    wd_r,
  output logic [DATA_W-1:0]    q_r
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // right applied first so left lanes override on the same word
  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (we_r && be_r[b]) mem[addr_r][b*8 +: 8] <= wd_r[b*8 +: 8];
      if (we_l && be_l[b]) mem[addr_l][b*8 +: 8] <= wd_l[b*8 +: 8];
    end
  end

  // read-before-write registered outputs
  always_ff @(posedge clk) begin
    if (re_l) q_l <= mem[addr_l];
    if (re_r) q_r <= mem[addr_r];
  end
endmodule

// File: rtl/dpbusy_arb.sv
module dpbusy_arb
  import dpbusy_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_sel,
  input  port_ctl_t     ctl_l,
  input  port_ctl_t     ctl_r,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  input  logic          hold_l,
  input  logic          hold_r,
  input  logic          busy_in_l,
  input  logic          busy_in_r,
  output logic          busy_out_l,
  output logic          busy_out_r,
  output logic          busy_eff_l,
  output logic          busy_eff_r
);
  owner_e owner_q, owner_d;
  logic   owner_en;
  logic   col;
  logic   lose_l, lose_r;

  assign col = ctl_l.act & ctl_r.act & (addr_l == addr_r) & (ctl_l.wr | ctl_r.wr);

  always_comb begin
    owner_d = OWN_NONE;
    if (col) begin
      if (owner_q != OWN_NONE) owner_d = owner_q;
      else if (hold_r && !hold_l) owner_d = OWN_RIGHT;
      else owner_d = OWN_LEFT;
    end
  end

  assign owner_en = col | (owner_q != OWN_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else if (owner_en) owner_q <= owner_d;
  end

  assign lose_l = col & (owner_d == OWN_RIGHT);
  assign lose_r = col & (owner_d == OWN_LEFT);

  assign busy_out_l = ms_sel & lose_l;
  assign busy_out_r = ms_sel & lose_r;
  assign busy_eff_l = ms_sel ? lose_l : busy_in_l;
  assign busy_eff_r = ms_sel ? lose_r : busy_in_r;
endmodule

// File: rtl/dpbusy_ram.sv
module dpbusy_ram
  import dpbusy_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_sel,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic          l_ub,
  input  logic          l_lb,
  input  logic [AW-1:0] l_addr,
  input  logic [15:0]   l_din,
  output logic [15:0]   l_dout,
  output logic          l_dvalid,
  input  logic          l_busy_in,
  output logic          l_busy_out,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic          r_ub,
  input  logic          r_lb,
  input  logic [AW-1:0] r_addr,
  input  logic [15:0]   r_din,
  output logic [15:0]   r_dout,
  output logic          r_dvalid,
  input  logic          r_busy_in,
  output logic          r_busy_out
);
  logic [1:0]        rst_pipe;
  logic              srst_n;
  port_ctl_t         ctl_l, ctl_r;
  logic              hold_l, hold_r;
  logic              beff_l, beff_r;
  logic [DATA_W-1:0] q_l, q_r;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  dpbusy_port #(.AW(AW)) u_port_l (
    .clk(clk), .rst_n(srst_n), .en(l_en), .wr(l_wr), .oe(l_oe),
    .ub(l_ub), .lb(l_lb), .addr(l_addr), .raw_q(q_l),
    .ctl(ctl_l), .hold(hold_l), .dout(l_dout), .dvalid(l_dvalid)
  );

  dpbusy_port #(.AW(AW)) u_port_r (
    .clk(clk), .rst_n(srst_n), .en(r_en), .wr(r_wr), .oe(r_oe),
    .ub(r_ub), .lb(r_lb), .addr(r_addr), .raw_q(q_r),
    .ctl(ctl_r), .hold(hold_r), .dout(r_dout), .dvalid(r_dvalid)
  );

  dpbusy_arb #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(srst_n), .ms_sel(ms_sel),
    .ctl_l(ctl_l), .ctl_r(ctl_r), .addr_l(l_addr), .addr_r(r_addr),
    .hold_l(hold_l), .hold_r(hold_r),
    .busy_in_l(l_busy_in), .busy_in_r(r_busy_in),
    .busy_out_l(l_busy_out), .busy_out_r(r_busy_out),
    .busy_eff_l(beff_l), .busy_eff_r(beff_r)
  );

  dpbusy_bank #(.AW(AW)) u_bank (
    .clk(clk),
    .we_l(ctl_l.wr & ~beff_l), .re_l(ctl_l.act & ~ctl_l.wr),
    .be_l(ctl_l.be), .addr_l(l_addr), .wd_l(l_din), .q_l(q_l),
    .we_r(ctl_r.wr & ~beff_r), .re_r(ctl_r.act & ~ctl_r.wr),
    .be_r(ctl_r.be), .addr_r(r_addr), .wd_r(r_din), .q_r(q_r)
  );
endmodule

// File: rtl/dpbusy_ram_chk.sv
module dpbusy_ram_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ms_sel,
  input logic          l_en,
  input logic          l_wr,
  input logic          l_oe,
  input logic          l_ub,
  input logic          l_lb,
  input logic [AW-1:0] l_addr,
  input logic [15:0]   l_dout,
  input logic          l_dvalid,
  input logic          l_busy_out,
  input logic          r_en,
  input logic          r_wr,
  input logic          r_oe,
  input logic          r_ub,
  input logic          r_lb,
  input logic [AW-1:0] r_addr,
  input logic [15:0]   r_dout,
  input logic          r_dvalid,
  input logic          r_busy_out
);
  logic clash;
  assign clash = l_en && r_en && (l_ub || l_lb) && (r_ub || r_lb) &&
                 (l_addr == r_addr) && (l_wr || r_wr);

  assert_single_loser_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_out && r_busy_out));

  assert_busy_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_out || r_busy_out) |-> clash);

  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_sel |-> (!l_busy_out && !r_busy_out));

  assert_keep_left_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && $past(ms_sel) && $past(r_busy_out) && clash) |-> r_busy_out);

  assert_keep_right_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_sel && $past(ms_sel) && $past(l_busy_out) && clash) |-> l_busy_out);

  assert_idle_zero_l_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !l_dvalid |-> (l_dout == '0));

  assert_idle_zero_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !r_dvalid |-> (r_dout == '0));

  assert_read_latency_l_R2: assert property (@(posedge clk) disable iff (!rst_n)
    l_dvalid |-> $past(l_en && !l_wr && l_oe && (l_ub || l_lb)));

  assert_read_latency_r_R2: assert property (@(posedge clk) disable iff (!rst_n)
    r_dvalid |-> $past(r_en && !r_wr && r_oe && (r_ub || r_lb)));
endmodule

bind dpbusy_ram dpbusy_ram_chk #(.AW(AW)) u_chk (.*);

// File: tb/dpbusy_ram_test.sv
module dpbusy_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  typedef struct packed {
    logic en, wr, oe, ub, lb;
    logic [AW-1:0] a;
    logic [15:0] d;
  } pin_t;

  typedef struct packed {
    logic dv;
    logic [15:0] q;
  } out_t;

  typedef struct packed {
    logic [3:0] req;
    pin_t l;
    pin_t r;
    logic lb;
    logic rb;
    out_t lo;
    out_t ro;
  } vec_t;

  localparam pin_t IDL = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'h0, 16'h0};
  localparam out_t NO  = '{1'b0, 16'h0};
  localparam int NV = 17;

  localparam vec_t TBL [NV] = '{
    // R1: plain writes on both ports
    '{4'd1, '{1,1,0,1,1,10'h010,16'h1234}, '{1,1,0,1,1,10'h020,16'hABCD}, 0,0, NO, NO},
    // R2: crossed reads
    '{4'd2, '{1,0,1,1,1,10'h020,16'h0}, '{1,0,1,1,1,10'h010,16'h0}, 0,0,
      '{1,16'hABCD}, '{1,16'h1234}},
    // R1: upper-only write; R2: lower-only read
    '{4'd1, '{1,1,0,1,0,10'h010,16'hFFEE}, '{1,0,1,0,1,10'h020,16'h0}, 0,0,
      NO, '{1,16'h00CD}},
    // R4: two reads of one word, no busy; R2: left oe low
    '{4'd4, '{1,0,0,1,1,10'h010,16'h0}, '{1,0,1,1,1,10'h010,16'h0}, 0,0,
      NO, '{1,16'hFF34}},
    // R6: fresh tie, left wins
    '{4'd6, '{1,1,0,1,1,10'h030,16'h5555}, '{1,1,0,1,1,10'h030,16'hAAAA}, 0,1, NO, NO},
    // R8: winner kept, right write dropped
    '{4'd8, '{1,0,1,1,1,10'h030,16'h0}, '{1,1,0,1,1,10'h030,16'h6666}, 0,1,
      '{1,16'h5555}, NO},
    // R7: right write had no effect; R8 busy released
    '{4'd7, IDL, '{1,0,1,1,1,10'h030,16'h0}, 0,0, NO, '{1,16'h5555}},
    // R5: right parks on word
    '{4'd5, IDL, '{1,1,0,1,1,10'h040,16'h1111}, 0,0, NO, NO},
    // R5: left arrives late and loses
    '{4'd5, '{1,1,0,1,1,10'h040,16'h3333}, '{1,1,0,1,1,10'h040,16'h2222}, 1,0, NO, NO},
    // R5: right's data kept
    '{4'd5, '{1,0,1,1,1,10'h040,16'h0}, IDL, 0,0, '{1,16'h2222}, NO},
    // R7: seed word
    '{4'd7, '{1,1,0,1,1,10'h050,16'h0101}, IDL, 0,0, NO, NO},
    // R7: busy read sees old value
    '{4'd7, '{1,1,0,1,1,10'h050,16'h7777}, '{1,0,1,1,1,10'h050,16'h0}, 0,1,
      NO, '{1,16'h0101}},
    // R7: winner's write landed
    '{4'd7, IDL, '{1,0,1,1,1,10'h050,16'h0}, 0,0, NO, '{1,16'h7777}},
    // R3: enables low, nothing happens
    '{4'd3, '{0,1,0,1,1,10'h050,16'h0000}, '{0,0,1,1,1,10'h050,16'h0}, 0,0, NO, NO},
    // R3: word unchanged
    '{4'd3, '{1,0,1,1,1,10'h050,16'h0}, IDL, 0,0, '{1,16'h7777}, NO},
    // R3: no byte selects = standby, no collision
    '{4'd3, '{1,1,0,0,0,10'h050,16'h0000}, '{1,1,0,1,1,10'h050,16'h8888}, 0,0, NO, NO},
    // R3: right write went through, left did not
    '{4'd3, '{1,0,1,1,1,10'h050,16'h0}, IDL, 0,0, '{1,16'h8888}, NO}
  };

  logic clk, rst_n, ms_sel;
  logic l_en, l_wr, l_oe, l_ub, l_lb, l_busy_in, l_busy_out, l_dvalid;
  logic r_en, r_wr, r_oe, r_ub, r_lb, r_busy_in, r_busy_out, r_dvalid;
  logic [AW-1:0] l_addr, r_addr;
  logic [15:0] l_din, r_din, l_dout, r_dout;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  dpbusy_ram #(.AW(AW)) uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input pin_t l, input pin_t r);
    l_en = l.en; l_wr = l.wr; l_oe = l.oe; l_ub = l.ub; l_lb = l.lb;
    l_addr = l.a; l_din = l.d;
    r_en = r.en; r_wr = r.wr; r_oe = r.oe; r_ub = r.ub; r_lb = r.lb;
    r_addr = r.a; r_din = r.d;
  endtask

  function automatic pin_t wr_p(input logic [AW-1:0] a, input logic [15:0] d);
    return '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, a, d};
  endfunction

  function automatic pin_t rd_p(input logic [AW-1:0] a);
    return '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, a, 16'h0};
  endfunction

  // one cycle: drive at negedge, busy before posedge, outputs after posedge
  task automatic step(input pin_t l, input pin_t r, input string req,
                      input logic eb_l, input logic eb_r,
                      input out_t elo, input out_t ero);
    @(negedge clk);
    drive(l, r);
    #(CLK_PERIOD/4);
    check({req, " left busy"}, 32'(l_busy_out), 32'(eb_l));
    check({req, " right busy"}, 32'(r_busy_out), 32'(eb_r));
    @(posedge clk);
    #(CLK_PERIOD/4);
    check({req, " left out"}, {15'h0, l_dvalid, l_dout}, 32'(elo));
    check({req, " right out"}, {15'h0, r_dvalid, r_dout}, 32'(ero));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ms_sel = 1'b1;
    l_busy_in = 1'b0;
    r_busy_in = 1'b0;
    drive(IDL, IDL);
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R11: reset state
    check("R11 busy", {30'h0, l_busy_out, r_busy_out}, 32'h0);
    check("R11 outs", {l_dvalid, r_dvalid, l_dout, r_dout[13:0]}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R11 after release", {l_dvalid, r_dvalid, l_dout, r_dout[13:0]}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].l, TBL[i].r, $sformatf("R%0d row %0d", TBL[i].req, i),
           TBL[i].lb, TBL[i].rb, TBL[i].lo, TBL[i].ro);
    end

    // R9: master mode ignores busy inputs
    l_busy_in = 1'b1;
    step(wr_p(10'h0A0, 16'h4242), IDL, "R9 master ignores in", 0, 0, NO, NO);
    l_busy_in = 1'b0;
    step(rd_p(10'h0A0), IDL, "R9 master write ok", 0, 0, '{1, 16'h4242}, NO);

    // R9: slave mode, busy from inputs, outputs quiet
    ms_sel = 1'b0;
    step(wr_p(10'h060, 16'h0F0F), IDL, "R9 slave seed", 0, 0, NO, NO);
    l_busy_in = 1'b1;
    step(wr_p(10'h060, 16'h1234), IDL, "R9 slave blocked", 0, 0, NO, NO);
    l_busy_in = 1'b0;
    step(rd_p(10'h060), IDL, "R9 slave kept", 0, 0, '{1, 16'h0F0F}, NO);
    // R9: same-word write collision raises no busy output in slave mode
    r_busy_in = 1'b1;
    step(wr_p(10'h061, 16'h5A5A), wr_p(10'h061, 16'hA5A5), "R9 slave right blocked",
         0, 0, NO, NO);
    r_busy_in = 1'b0;
    step(IDL, rd_p(10'h061), "R9 slave right kept", 0, 0, NO, '{1, 16'h5A5A});

    // R10: unblocked double write, left lanes win
    step(wr_p(10'h070, 16'h1111), wr_p(10'h070, 16'h2222), "R10 double write",
         0, 0, NO, NO);
    step(IDL, rd_p(10'h070), "R10 left precedence", 0, 0, NO, '{1, 16'h1111});
    step('{1,1,0,1,0,10'h071,16'h33FF}, '{1,1,0,0,1,10'h071,16'hFF44},
         "R10 split lanes", 0, 0, NO, NO);
    step(rd_p(10'h071), IDL, "R10 merged word", 0, 0, '{1, 16'h3344}, NO);

    drive(IDL, IDL);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule